// File: doc/BRIEF.md
# Strap Latch and Clock Configuration Controller

This block sits beside a clock synthesizer and turns two sources of configuration into the control words that steer it. When power-on reset is released it samples, once, the levels on five dual-purpose pins (four frequency-select straps and a mode strap) and then hands those pins over to output use. From then on the sampled values are frozen, whatever the pins do.

Software holds six configuration bytes, reached through a simple indexed write port and a combinational read port. Byte 0 picks where the 5-bit frequency code comes from: the frozen straps, or a code written by software. It also carries a spread-spectrum enable and a global tristate. Bytes 1, 2, 3 and 5 hold per-output run enables, where a cleared bit means that output is held low. Byte 4 is read-only. Reading bytes 1, 3 and 4 reports the frozen straps inverted, and reserved bits read as 1. The outputs are control words only. The frequency table and the analog synthesis sit downstream.

Top module: `clkcfg_strap_ctl`

## Requirements
- R1: While `rst_n` is low, `pins_out_en_o` is 0. Right after release, every run-enable output is 1, `tristate_o` is 0, `spread_en_o` is 0 and byte 0 reads 0x50.
- R2: The straps are captured at the first rising clock edge with `rst_n` high, and `pins_out_en_o` rises at that edge. Later pin changes do not alter `freq_code_o`, `strap_mode_o` or the strap readback bits.
- R3: With byte 0 bit 3 = 0, `freq_code_o` = {0, captured FS[3:0]}, and `strap_mode_o` is the captured mode pin.
- R4: With byte 0 bit 3 = 1, `freq_code_o` = {bit2, bit7, bit6, bit5, bit4} of byte 0, with bit 2 as the MSB. The new code appears one clock after the write.
- R5: `spread_en_o` equals byte 0 bit 1.
- R6: Byte 0 bit 0 = 1 sets `tristate_o`. While it is set, every run-enable output is 0, whatever bytes 1 to 5 hold. Those bytes keep their stored values.
- R7: Run-enable mapping, where a bit value of 1 means the output runs:
  - byte 1: bit 0 → `cpu_run_o[0]`, bit 1 → `cpu_run_o[1]`, bit 3 → `sdram_f_run_o`;
  - byte 2: bits 4:0 → `pci_run_o[4:0]`, bit 6 → `pci_f_run_o`;
  - byte 3: bits 2:0 → `sdram_run_o[2:0]`, bit 4 → `clk24_run_o`, bit 5 → `clk48_run_o`;
  - byte 5: bits 1:0 → `ref_run_o[1:0]`, bit 4 → `ioapic_run_o`.
- R8: Readback reports the inverted captured straps at these positions: FS2 at byte 1 bit 7, FS0 at byte 3 bit 6, FS1 at byte 4 bit 3, FS3 at byte 4 bit 1.
- R9: Bits not named in R7 or R8 read 1 in bytes 1 to 5. Writes to those bits, to the strap positions, and anywhere in byte 4 have no effect on readback or outputs.
- R10: Byte 0 reads back exactly as written, and all eight of its bits are writable.
- R11: Indices 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| strap_fs_i | input | 4 | Frequency-select strap pin levels |
| strap_mode_i | input | 1 | Mode strap pin level |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_idx_i | input | 3 | Byte index for write |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 3 | Byte index for readback |
| rd_data_o | output | 8 | Readback data (combinational) |
| pins_out_en_o | output | 1 | Strap pins released for output use |
| strap_mode_o | output | 1 | Captured mode strap |
| freq_code_o | output | 5 | Active frequency code |
| spread_en_o | output | 1 | Center-spread modulation enable |
| tristate_o | output | 1 | Global output tristate |
| cpu_run_o | output | 2 | CPU clock run enables |
| sdram_f_run_o | output | 1 | Free SDRAM clock run enable |
| pci_f_run_o | output | 1 | Free PCI clock run enable |
| pci_run_o | output | 5 | PCI clock run enables |
| sdram_run_o | output | 3 | SDRAM group run enables |
| clk48_run_o | output | 1 | 48 MHz clock run enable |
| clk24_run_o | output | 1 | 24 MHz clock run enable |
| ioapic_run_o | output | 1 | Interrupt-controller clock run enable |
| ref_run_o | output | 2 | Reference clock run enables |

## Verification
All 32 combinations of the four frequency straps and the mode strap are captured through separate resets. After each capture the pins are driven to their complement, which tells a correct one-shot latch apart from one that keeps tracking the pins. All 32 software codes are written, which exposes any misordering of the bit-2-as-MSB concatenation. A walking zero is written into every bit of each enable byte, which separates a correct bit mapping from a swapped or shifted one, and shows which positions are reserved or read-only. The tristate is tried with every enable set, to show that it overrides them and leaves the stored enables intact.

// File: rtl/clkcfg_strap_ctl.sv
module clkcfg_strap_ctl #(
  parameter int FS_W  = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FS_W-1:0]  strap_fs_i,
  input  logic             strap_mode_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             pins_out_en_o,
  output logic             strap_mode_o,
  output logic [FS_W:0]    freq_code_o,
  output logic             spread_en_o,
  output logic             tristate_o,
  output logic [1:0]       cpu_run_o,
  output logic             sdram_f_run_o,
  output logic             pci_f_run_o,
  output logic [4:0]       pci_run_o,
  output logic [2:0]       sdram_run_o,
  output logic             clk48_run_o,
  output logic             clk24_run_o,
  output logic             ioapic_run_o,
  output logic [1:0]       ref_run_o
);
  localparam int CODE_W = FS_W + 1;
  localparam logic [7:0] DEF0  = 8'h50;
  localparam logic [7:0] WMSK1 = 8'h0B;
  localparam logic [7:0] WMSK2 = 8'h5F;
  localparam logic [7:0] WMSK3 = 8'h37;
  localparam logic [7:0] WMSK5 = 8'h13;
  localparam logic [7:0] FIX1  = 8'h74;
  localparam logic [7:0] FIX2  = 8'hA0;
  localparam logic [7:0] FIX3  = 8'h88;
  localparam logic [7:0] FIX4  = 8'hF5;
  localparam logic [7:0] FIX5  = 8'hEC;

  logic            latched;
  logic [FS_W-1:0] fs_q;
  logic            mode_q;
  logic [7:0]      cfg0, cfg1, cfg2, cfg3, cfg5;
  logic [FS_W-1:0] fs_n;
  logic            run_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      fs_q    <= '0;
      mode_q  <= 1'b0;
    end else if (!latched) begin
      latched <= 1'b1;
      fs_q    <= strap_fs_i;
      mode_q  <= strap_mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0 <= DEF0;
      cfg1 <= WMSK1;
      cfg2 <= WMSK2;
      cfg3 <= WMSK3;
      cfg5 <= WMSK5;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        3'd0: cfg0 <= wr_data_i;
        3'd1: cfg1 <= wr_data_i & WMSK1;
        3'd2: cfg2 <= wr_data_i & WMSK2;
        3'd3: cfg3 <= wr_data_i & WMSK3;
        3'd5: cfg5 <= wr_data_i & WMSK5;
        default: ;
      endcase
    end
  end

  assign fs_n = ~fs_q;

  always_comb begin
    case (rd_idx_i)
      3'd0:    rd_data_o = cfg0;
      3'd1:    rd_data_o = cfg1 | FIX1 | {fs_n[2], 7'b0};
      3'd2:    rd_data_o = cfg2 | FIX2;
      3'd3:    rd_data_o = cfg3 | FIX3 | {1'b0, fs_n[0], 6'b0};
      3'd4:    rd_data_o = FIX4 | {4'b0, fs_n[1], 1'b0, fs_n[3], 1'b0};
      3'd5:    rd_data_o = cfg5 | FIX5;
      default: rd_data_o = 8'h00;
    endcase
  end

  assign pins_out_en_o = latched;
  assign strap_mode_o  = mode_q;
  assign freq_code_o   = cfg0[3] ? {cfg0[2], cfg0[7:4]} : {1'b0, fs_q};
  assign spread_en_o   = cfg0[1];
  assign tristate_o    = cfg0[0];
  assign run_ok        = ~cfg0[0];

  assign cpu_run_o     = cfg1[1:0] & {2{run_ok}};
  assign sdram_f_run_o = cfg1[3] & run_ok;
  assign pci_run_o     = cfg2[4:0] & {5{run_ok}};
  assign pci_f_run_o   = cfg2[6] & run_ok;
  assign sdram_run_o   = cfg3[2:0] & {3{run_ok}};
  assign clk24_run_o   = cfg3[4] & run_ok;
  assign clk48_run_o   = cfg3[5] & run_ok;
  assign ref_run_o     = cfg5[1:0] & {2{run_ok}};
  assign ioapic_run_o  = cfg5[4] & run_ok;

  p_pins_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pins_out_en_o |=> pins_out_en_o);

  p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_out_en_o && $past(pins_out_en_o)) |-> ($stable(strap_mode_o) && $stable(fs_q)));

  p_hw_msb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_out_en_o && !cfg0[3]) |-> (freq_code_o[CODE_W-1] == 1'b0));

  p_sw_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 3'd0 && wr_data_i[3]) |=>
      (freq_code_o == {$past(wr_data_i[2]), $past(wr_data_i[7:4])}));

  p_tri_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_o |-> ({cpu_run_o, sdram_f_run_o, pci_f_run_o, pci_run_o, sdram_run_o,
                     clk48_run_o, clk24_run_o, ioapic_run_o, ref_run_o} == '0));

  p_rb4_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i == 3'd4) |-> (rd_data_o[7:4] == 4'hF && rd_data_o[2] && rd_data_o[0]));

  p_hi_idx_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i[2:1] == 2'b11) |-> (rd_data_o == 8'h00));
endmodule

// File: tb/clkcfg_strap_ctl_tb_top.sv
module clkcfg_strap_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strap_fs = 4'h0;
  logic       strap_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_idx = 3'd0;
  logic [7:0] rd_data;
  logic       pins_oe, mode_o, spread, tri_o;
  logic [4:0] code;
  logic [1:0] cpu_run, ref_run;
  logic       sdf_run, pcif_run, c48_run, c24_run, ioa_run;
  logic [4:0] pci_run;
  logic [2:0] sd_run;

  int tests = 0;
  int fails = 0;
  logic [7:0] w [0:7];
  logic [3:0] fs_cap;

  always #5 clk = ~clk;

  clkcfg_strap_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .strap_fs_i(strap_fs), .strap_mode_i(strap_mode),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .pins_out_en_o(pins_oe), .strap_mode_o(mode_o),
    .freq_code_o(code), .spread_en_o(spread), .tristate_o(tri_o),
    .cpu_run_o(cpu_run), .sdram_f_run_o(sdf_run), .pci_f_run_o(pcif_run),
    .pci_run_o(pci_run), .sdram_run_o(sd_run), .clk48_run_o(c48_run),
    .clk24_run_o(c24_run), .ioapic_run_o(ioa_run), .ref_run_o(ref_run));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] run_vec();
    return {cpu_run, sdf_run, pcif_run, pci_run, sd_run, c48_run, c24_run, ioa_run, ref_run};
  endfunction

  function automatic logic [16:0] run_exp();
    if (w[0][0]) return '0;
    return {w[1][1], w[1][0], w[1][3], w[2][6], w[2][4:0], w[3][2:0],
            w[3][5], w[3][4], w[5][4], w[5][1:0]};
  endfunction

  function automatic logic [7:0] rb_exp(input int i);
    logic [3:0] n;
    n = ~fs_cap;
    case (i)
      0: return w[0];
      1: return (w[1] & 8'h0B) | 8'h74 | {n[2], 7'b0};
      2: return (w[2] & 8'h5F) | 8'hA0;
      3: return (w[3] & 8'h37) | 8'h88 | {1'b0, n[0], 6'b0};
      4: return 8'hF5 | {4'b0, n[1], 1'b0, n[3], 1'b0};
      5: return (w[5] & 8'h13) | 8'hEC;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_reset(input logic [3:0] fs, input logic md);
    @(negedge clk);
    rst_n = 1'b0;
    strap_fs = fs;
    strap_mode = md;
    repeat (2) @(negedge clk);
    chk("R1 pins held as inputs in reset", pins_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    w[0] = 8'h50;
    for (int i = 1; i < 8; i++) w[i] = 8'hFF;
    fs_cap = fs;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = idx[2:0];
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx != 4 && idx < 6) w[idx] = d;
  endtask

  task automatic chk_rb(input string req, input int i);
    rd_idx = i[2:0];
    #1;
    chk(req, rd_data, rb_exp(i));
  endtask

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 32; s++) begin
      do_reset(s[3:0], s[4]);
      chk("R2 pins released", pins_oe, 1'b1);
      chk("R3 hw code", code, {1'b0, s[3:0]});
      chk("R3 mode strap", mode_o, s[4]);
      if (s == 0) begin
        chk("R1 default runs", run_vec(), 17'h1FFFF);
        chk("R1 default tristate", tri_o, 1'b0);
        chk("R1 default spread", spread, 1'b0);
        chk_rb("R1 byte0 default 50", 0);
      end
      chk_rb("R8 strap readback b1", 1);
      chk_rb("R8 strap readback b3", 3);
      chk_rb("R8 strap readback b4", 4);
      strap_fs = ~s[3:0];
      strap_mode = ~s[4];
      repeat (3) @(negedge clk);
      chk("R2 code frozen", code, {1'b0, s[3:0]});
      chk("R2 mode frozen", mode_o, s[4]);
      chk_rb("R2 readback frozen b4", 4);
      chk_rb("R2 readback frozen b1", 1);
    end

    do_reset(4'hA, 1'b1);
    for (int c = 0; c < 32; c++) begin
      wr(0, {c[3:0], 1'b1, c[4], 2'b00});
      chk("R4 sw code", code, c[4:0]);
      chk_rb("R10 byte0 readback", 0);
    end
    wr(0, 8'hF0);
    chk("R3 back to hw code", code, 5'h0A);

    wr(0, 8'h02);
    chk("R5 spread on", spread, 1'b1);
    chk("R5 no tristate", tri_o, 1'b0);
    wr(0, 8'h00);
    chk("R5 spread off", spread, 1'b0);

    for (int i = 1; i < 6; i++) begin
      for (int b = 0; b < 8; b++) begin
        wr(i, ~(8'h01 << b));
        chk("R7 walk runs", run_vec(), run_exp());
        chk_rb("R9 walk readback", i);
        wr(i, 8'hFF);
      end
      wr(i, 8'h00);
      chk("R7 all-zero runs", run_vec(), run_exp());
      chk_rb("R9 zero-write readback", i);
      wr(i, 8'hFF);
    end

    wr(0, 8'h01);
    chk("R6 tristate on", tri_o, 1'b1);
    chk("R6 runs forced low", run_vec(), 17'h0);
    chk_rb("R6 enables kept", 2);
    wr(0, 8'hFF);
    chk("R6 tristate with sw code", run_vec(), 17'h0);
    chk("R4 code under tristate", code, 5'h1F);
    wr(0, 8'h00);
    chk("R6 runs restored", run_vec(), 17'h1FFFF);

    for (int i = 6; i < 8; i++) begin
      wr(i, 8'h00);
      chk_rb("R11 high index reads 0", i);
      chk("R11 write no effect", run_vec(), 17'h1FFFF);
      chk_rb("R11 byte0 untouched", 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule